// File: doc/BRIEF.md
# Serial Command Line Decoder

This block watches a single command wire that is sampled once per clock and turns the short bit patterns on it into separate one-cycle strobes for trigger, calibrate and reset. An occupancy tracker further down the chain uses these strobes, and it must see command timing identical to the front-end chips that receive the same wire. For that reason, every command is reported at one fixed latency, whichever command it is.

A command starts with a `1` bit while the line is idle. The two bits that follow complete a three-bit window. `1 0 0` is a trigger. `1 0 1` is a reset. `1 1 x` is a calibrate. A lone leading `1` is ambiguous until both later bits have been seen. The decoder therefore always decides on the third bit, and it also holds calibrate back to that point even though calibrate is known one bit earlier. All three bits of the window are used up, so a `1` in the third slot never starts a new command.

After a reset command, the front end needs a recovery interval before it can take triggers. The block drives a ready output that stays low for a programmable number of cycles. A trigger that is decoded while ready is low is still passed on, and an early-trigger flag is raised alongside it.

Top module: `cmd_line_decoder`

## Requirements
- R1: The bits `1`,`0`,`0`, sampled on three consecutive rising edges starting from idle, make `trig_o` high for exactly one cycle, right after the edge that samples the third bit.
- R2: The bits `1`,`1`,`x` raise `cal_o` for one cycle at the same point, after the edge that samples the third bit, and the value of the third bit does not matter.
- R3: The bits `1`,`0`,`1` raise `rst_cmd_o` for one cycle at the same point, after the edge that samples the third bit.
- R4: The decoder returns to idle after the third bit of every command, and that bit never starts a new command. At most one strobe is high in any cycle, and two strobes are always at least three cycles apart.
- R5: `ready_o` is low for exactly `READY_WAIT` cycles, beginning in the cycle in which `rst_cmd_o` is high, and goes high again after that.
- R6: `trig_early_o` is high exactly in the cycles where `trig_o` is high while `ready_o` is low. A trigger in the first cycle with `ready_o` high is not flagged.
- R7: A reset command that arrives while `ready_o` is low restarts the not-ready interval at its full length.
- R8: While `rst_n` is low, and after it is released, all strobes are low and `ready_o` is high. Any partly received command and any running not-ready interval are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the command bit is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 1 | Serial command bit |
| trig_o | output | 1 | One-cycle trigger strobe |
| cal_o | output | 1 | One-cycle calibrate strobe |
| rst_cmd_o | output | 1 | One-cycle reset-command strobe |
| ready_o | output | 1 | Low during the post-reset recovery interval |
| trig_early_o | output | 1 | Trigger decoded while not ready |

## Verification
If the state register is wrong, a command is misclassified. That shows at the ports as a wrong strobe, or a strobe in the wrong cycle, exactly two edges after the leading bit. If a state is not cleared, the next command shows a phantom trigger three cycles after the leftover bit. A wrong recovery counter shows up as a shifted rising edge on `ready_o`, or as a missing or extra `trig_early_o`, at the boundary of the interval. The bench probes both the last flagged cycle and the first unflagged cycle of that interval.

// File: rtl/cmd_line_decoder.sv
module cmd_line_decoder #(
  parameter int unsigned READY_WAIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_in,
  output logic trig_o,
  output logic cal_o,
  output logic rst_cmd_o,
  output logic ready_o,
  output logic trig_early_o
);

  localparam int unsigned CW = $clog2(READY_WAIT + 2);

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_ONE_ZERO, S_ONE_ONE} state_t;

  state_t        state, state_nx;
  logic [CW-1:0] wait_cnt;
  logic          dec_trig, dec_cal, dec_rst;

  assign dec_trig = (state == S_ONE_ZERO) && !cmd_in;
  assign dec_rst  = (state == S_ONE_ZERO) &&  cmd_in;
  assign dec_cal  = (state == S_ONE_ONE);

  always_comb begin
    unique case (state)
      S_IDLE:  state_nx = cmd_in ? S_ONE : S_IDLE;
      S_ONE:   state_nx = cmd_in ? S_ONE_ONE : S_ONE_ZERO;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      wait_cnt     <= '0;
      trig_o       <= 1'b0;
      cal_o        <= 1'b0;
      rst_cmd_o    <= 1'b0;
      trig_early_o <= 1'b0;
    end else begin
      state        <= state_nx;
      trig_o       <= dec_trig;
      cal_o        <= dec_cal;
      rst_cmd_o    <= dec_rst;
      trig_early_o <= dec_trig && (wait_cnt > CW'(1));
      if (dec_rst)
        wait_cnt <= CW'(READY_WAIT);
      else if (wait_cnt != '0)
        wait_cnt <= wait_cnt - CW'(1);
    end
  end

  assign ready_o = (wait_cnt == '0);

endmodule

// File: rtl/cmd_line_decoder_chk.sv
module cmd_line_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_in,
  input logic trig_o,
  input logic cal_o,
  input logic rst_cmd_o,
  input logic ready_o,
  input logic trig_early_o
);

  logic any_strobe;
  assign any_strobe = trig_o | cal_o | rst_cmd_o;

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_o, cal_o, rst_cmd_o}));

  assert_strobe_gap1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> !any_strobe);

  assert_strobe_gap2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> ##1 !any_strobe);

  assert_trig_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(cmd_in, 3) && !$past(cmd_in, 2) && !$past(cmd_in, 1)));

  assert_cal_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_o |-> ($past(cmd_in, 3) && $past(cmd_in, 2)));

  assert_rst_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_o |-> ($past(cmd_in, 3) && !$past(cmd_in, 2) && $past(cmd_in, 1)));

  assert_reset_notready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_o |-> !ready_o);

  assert_early_implies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_early_o |-> (trig_o && !ready_o));

  assert_early_required_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && !ready_o) |-> trig_early_o);

endmodule

bind cmd_line_decoder cmd_line_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .trig_o(trig_o), .cal_o(cal_o),
  .rst_cmd_o(rst_cmd_o), .ready_o(ready_o), .trig_early_o(trig_early_o)
);

// File: tb/test_cmd_line_decoder.sv
module test_cmd_line_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LEN   = 6;
  localparam int NVEC       = 63;

  // {cmd bit, trig, cal, rst, ready, early} expected after the edge sampling the bit
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0_00010, 6'b1_00010, 6'b0_00010, 6'b0_10010,            // R1 trigger
    6'b1_00010, 6'b1_00010, 6'b1_01010,                        // R2 calibrate, third bit 1
    6'b0_00010, 6'b0_00010,                                    // R4 no phantom start
    6'b1_00010, 6'b0_00010, 6'b1_00100,                        // R3 reset, R5 window
    6'b1_00000, 6'b0_00000, 6'b0_10001,                        // R6 early trigger
    6'b0_00000, 6'b0_00000, 6'b0_00010,                        // R5 ready back
    6'b1_00010, 6'b0_00010, 6'b1_00100,
    6'b0_00000, 6'b0_00000, 6'b0_00000, 6'b1_00000, 6'b0_00000,
    6'b0_10010,                                                // R6 first ready cycle: no flag
    6'b1_00010, 6'b0_00010, 6'b1_00100,
    6'b1_00000, 6'b0_00000, 6'b1_00100,                        // R7 restart
    6'b0_00000, 6'b0_00000, 6'b0_00000, 6'b0_00000, 6'b0_00000,
    6'b0_00010,
    6'b1_00010, 6'b0_00010, 6'b0_10010,                        // R1 back-to-back
    6'b1_00010, 6'b0_00010, 6'b0_10010,
    6'b1_00010, 6'b1_00010, 6'b0_01010,                        // R2 third bit 0
    6'b1_00010, 6'b1_00010, 6'b1_01010,                        // R4 continuous ones
    6'b1_00010, 6'b0_00010, 6'b0_10010,
    6'b1_00010, 6'b0_00010, 6'b1_00100,
    6'b0_00000, 6'b0_00000, 6'b1_00000, 6'b0_00000,
    6'b0_10001,                                                // R6 last flagged cycle
    6'b0_00010
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_in = 1'b0;
  logic trig_o, cal_o, rst_cmd_o, ready_o, trig_early_o;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmd_line_decoder #(.READY_WAIT(WAIT_LEN)) i_cmd_line_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .trig_o(trig_o), .cal_o(cal_o),
    .rst_cmd_o(rst_cmd_o), .ready_o(ready_o), .trig_early_o(trig_early_o)
  );

  function automatic string tag_of(input logic [4:0] diff);
    if (diff[4]) return "R1/R4";
    if (diff[3]) return "R2";
    if (diff[2]) return "R3";
    if (diff[1]) return "R5/R7";
    return "R6";
  endfunction

  task automatic check(input logic [4:0] exp, input string where);
    logic [4:0] act;
    act = {trig_o, cal_o, rst_cmd_o, ready_o, trig_early_o};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", tag_of(act ^ exp), where, act, exp);
    end
  endtask

  task automatic apply(input logic b);
    cmd_in = b;
    @(negedge clk);
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(5'b00010, "R8 reset state");

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][5]);
      check(VEC[i][4:0], $sformatf("vector %0d", i));
    end

    // R8: partial command is dropped by hardware reset
    apply(1'b1);
    apply(1'b0);
    hw_reset();
    check(5'b00010, "R8 after reset mid-command");
    apply(1'b0);
    check(5'b00010, "R8 no trigger from dropped prefix");
    apply(1'b0);
    check(5'b00010, "R8 still idle");

    // R8: hardware reset ends a running not-ready interval
    apply(1'b1);
    apply(1'b0);
    apply(1'b1);
    check(5'b00100, "R3 reset strobe before hw reset");
    hw_reset();
    check(5'b00010, "R8 ready restored by hw reset");
    apply(1'b1);
    apply(1'b0);
    apply(1'b0);
    check(5'b10010, "R8 trigger after hw reset not early");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule